// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level Interrupts

This block sits between a register bus and the serial framer of an audio port. Software writes playback samples into a transmit queue and reads captured samples out of a receive queue. The framer takes playback words from a valid/ready output stream and offers captured words on a valid/ready input stream. Each queue reports a live fill count and four level flags. Each queue also drives a DMA request line, which compares the fill count against a programmable watermark.

Every level flag, and every error in either direction, also sets a sticky event bit. Per-event enables mask these bits into one pending summary. A global enable gates that summary onto the interrupt line. Software clears event bits by writing ones to a clear register.

Stream rules: `tx_valid` is high while the transmit queue is enabled and holds data. A word leaves the queue on a cycle with `tx_valid && tx_ready`. `rx_ready` is high whenever the receive queue is enabled, so the framer is never held back. A word offered while the queue is full is dropped and counts as an overflow.

Top module: `aud_fifo_irq`

## Requirements
- R1: A bus write to address 1 (when the TX queue is enabled) appends `reg_wdata[15:0]`. The samples leave on `tx_data` in write order, one per `tx_valid && tx_ready` cycle. `tx_valid` is high exactly when TX is enabled and its count is non-zero, and `tx_data` reads 0 when `tx_valid` is low.
- R2: `rx_ready` equals the RX enable. A bus read of address 2 with `reg_re` returns bit 16 = 1 and bits 15:0 = the oldest RX word, and it removes that word. When RX is disabled or empty, the read returns 0 and removes nothing.
- R3: Address 5 returns TX count in bits 19:14 and RX count in bits 9:4. The TX flags are empty (bit 13), almost-empty (bit 12), full (bit 11) and almost-full (bit 10). The RX flags are in the same order at bits 3..0. Almost-empty means count <= 2, almost-full means count >= depth-2, and full means count = depth (32).
- R4: A TX push to a full queue is dropped and sets event bit 6. An RX word offered to a full queue is dropped and sets event bit 0.
- R5: `tx_ready` while TX is enabled and empty sets event bit 7. A read of address 2 while RX is enabled and empty sets event bit 1.
- R6: Address 4 holds sticky events. For each enabled queue, every cycle its empty, almost-empty, full and almost-full flags set bits 11, 10, 9, 8 (TX) or 5, 4, 3, 2 (RX). Bit 12 is set on any handshake on either stream.
- R7: A write to address 6 clears each event bit whose data bit is 1. An event that sets in the same cycle wins over the clear.
- R8: Status bit 13 is high when any event bit is set together with its enable (address 3, same bit). `irq` equals that summary ANDed with enable bit 14.
- R9: `tx_dma_req` is high while the TX DMA enable and TX enable are on and TX count <= TX watermark. `rx_dma_req` is high while the RX DMA enable and RX enable are on and RX count >= RX watermark.
- R10: While a queue's enable is 0 it is flushed: its count reads 0 one cycle after the enable drops, and its earlier data is lost.
- R11: Address 0 reads back the fields RX enable (bit 1), TX enable (bit 2), RX DMA enable (bit 5), TX DMA enable (bit 6), RX watermark (bits 12:7) and TX watermark (bits 18:13). Address 3 reads back enables 12:0 and global bit 14. All other bits read 0, and every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RX at address 2) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_valid | output | 1 | Playback word available |
| tx_ready | input | 1 | Framer takes a playback word |
| tx_data | output | 16 | Playback word |
| rx_valid | input | 1 | Framer offers a captured word |
| rx_ready | output | 1 | Capture queue accepting |
| rx_data | input | 16 | Captured word |
| tx_dma_req | output | 1 | Playback watermark request |
| rx_dma_req | output | 1 | Capture watermark request |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an event that sets in the same cycle software clears it, while the queue sits at a boundary. The stimulus fills TX to 32 and writes the clear register while the full condition persists, then drains it under a pseudo-random ready pattern until starvation fires. The RX side gets a long burst of offered words past depth, followed by reads past empty. A later phase flushes a part-filled queue and mixes random pushes, pops and reads, so that count boundaries, watermarks and event bits are compared every cycle against a queue-based model.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_TXD  = 3'd1,
    A_RXD  = 3'd2,
    A_IEN  = 3'd3,
    A_IST  = 3'd4,
    A_FST  = 3'd5,
    A_CLR  = 3'd6
  } reg_addr_e;

  // level flags; packed order matches the status layout (empty highest)
  typedef struct packed {
    logic empty;
    logic aempty;
    logic full;
    logic afull;
  } lvl_t;

  localparam int EV_W    = 13;
  localparam int EV_RX   = 0;   // base of RX event group
  localparam int EV_TX   = 6;   // base of TX event group
  localparam int EV_XFER = 12;
  localparam int OF_OVF  = 0;
  localparam int OF_STV  = 1;
  localparam int OF_LVL  = 2;   // four level flags at +2..+5

  localparam int CB_RXEN    = 1;
  localparam int CB_TXEN    = 2;
  localparam int CB_RXDMA   = 5;
  localparam int CB_TXDMA   = 6;
  localparam int RXTHR_LSB  = 7;
  localparam int TXTHR_LSB  = 13;
  localparam int IEN_GLOBAL = 14;
  localparam int ST_PEND    = 13;
  localparam int FS_RXFLG   = 0;
  localparam int FS_RXCNT   = 4;
  localparam int FS_TXFLG   = 10;
  localparam int FS_TXCNT   = 14;
  localparam int FLD_W      = 6;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo import aud_fifo_pkg::*; #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32,
  parameter int AGAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output lvl_t             flags
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign flags.empty  = (count == '0);
  assign flags.full   = (count == CW'(DEPTH));
  assign flags.aempty = (count <= CW'(AGAP));
  assign flags.afull  = (count >= CW'(DEPTH - AGAP));
  assign do_push = push && !flags.full && !flush;
  assign do_pop  = pop && !flags.empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.full && push && !pop && !flush) |=> (count == $past(count)));
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] stat,
  output logic         pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | set;
  end

  assign pending = |(stat & en);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((stat & $past(set)) == $past(set)));
  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((stat & $past(clr & ~set)) == '0));
endmodule

// File: rtl/aud_fifo_irq.sv
module aud_fifo_irq import aud_fifo_pkg::*; #(
  parameter int SW    = 16,
  parameter int DEPTH = 32,
  parameter int AGAP  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [SW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [SW-1:0] rx_data,
  output logic          tx_dma_req,
  output logic          rx_dma_req,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH+1);

  reg_addr_e             sel;
  logic                  tx_en_q, rx_en_q, tx_dma_q, rx_dma_q, gen_q;
  logic [FLD_W-1:0]      tx_thr_q, rx_thr_q;
  logic [EV_W-1:0]       ien_q, ev_set, ev_clr, ev_stat;
  logic                  pending;
  logic [SW-1:0]         tx_head, rx_head;
  logic [CW-1:0]         tx_cnt, rx_cnt;
  lvl_t                  tx_flags, rx_flags;
  logic                  tx_push_req, rx_pop_req, rx_push_req;

  assign sel = reg_addr_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0; rx_en_q <= 1'b0;
      tx_dma_q <= 1'b0; rx_dma_q <= 1'b0;
      tx_thr_q <= '0; rx_thr_q <= '0;
      ien_q <= '0; gen_q <= 1'b0;
    end else if (reg_we) begin
      if (sel == A_CTRL) begin
        rx_en_q  <= reg_wdata[CB_RXEN];
        tx_en_q  <= reg_wdata[CB_TXEN];
        rx_dma_q <= reg_wdata[CB_RXDMA];
        tx_dma_q <= reg_wdata[CB_TXDMA];
        rx_thr_q <= reg_wdata[RXTHR_LSB +: FLD_W];
        tx_thr_q <= reg_wdata[TXTHR_LSB +: FLD_W];
      end
      if (sel == A_IEN) begin
        ien_q <= reg_wdata[EV_W-1:0];
        gen_q <= reg_wdata[IEN_GLOBAL];
      end
    end
  end

  assign tx_push_req = reg_we && (sel == A_TXD) && tx_en_q;
  assign rx_pop_req  = reg_re && (sel == A_RXD) && rx_en_q;
  assign rx_ready    = rx_en_q;
  assign rx_push_req = rx_valid && rx_en_q;
  assign tx_valid    = tx_en_q && !tx_flags.empty;
  assign tx_data     = tx_valid ? tx_head : '0;

  sample_fifo #(.WIDTH(SW), .DEPTH(DEPTH), .AGAP(AGAP)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en_q),
    .push(tx_push_req), .push_data(reg_wdata[SW-1:0]),
    .pop(tx_valid && tx_ready),
    .head(tx_head), .count(tx_cnt), .flags(tx_flags)
  );

  sample_fifo #(.WIDTH(SW), .DEPTH(DEPTH), .AGAP(AGAP)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en_q),
    .push(rx_push_req), .push_data(rx_data),
    .pop(rx_pop_req),
    .head(rx_head), .count(rx_cnt), .flags(rx_flags)
  );

  always_comb begin
    ev_set = '0;
    ev_set[EV_TX+OF_LVL +: 4] = tx_en_q ? tx_flags : 4'b0;
    ev_set[EV_RX+OF_LVL +: 4] = rx_en_q ? rx_flags : 4'b0;
    ev_set[EV_TX+OF_OVF] = tx_push_req && tx_flags.full;
    ev_set[EV_TX+OF_STV] = tx_en_q && tx_ready && tx_flags.empty;
    ev_set[EV_RX+OF_OVF] = rx_push_req && rx_flags.full;
    ev_set[EV_RX+OF_STV] = rx_pop_req && rx_flags.empty;
    ev_set[EV_XFER]      = (tx_valid && tx_ready) || (rx_valid && rx_ready);
  end

  assign ev_clr = (reg_we && sel == A_CLR) ? reg_wdata[EV_W-1:0] : '0;

  irq_stat_bank #(.W(EV_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr), .en(ien_q),
    .stat(ev_stat), .pending(pending)
  );

  assign irq        = gen_q && pending;
  assign tx_dma_req = tx_dma_q && tx_en_q && (FLD_W'(tx_cnt) <= tx_thr_q);
  assign rx_dma_req = rx_dma_q && rx_en_q && (FLD_W'(rx_cnt) >= rx_thr_q);

  always_comb begin
    reg_rdata = '0;
    case (sel)
      A_CTRL: begin
        reg_rdata[CB_RXEN]  = rx_en_q;
        reg_rdata[CB_TXEN]  = tx_en_q;
        reg_rdata[CB_RXDMA] = rx_dma_q;
        reg_rdata[CB_TXDMA] = tx_dma_q;
        reg_rdata[RXTHR_LSB +: FLD_W] = rx_thr_q;
        reg_rdata[TXTHR_LSB +: FLD_W] = tx_thr_q;
      end
      A_RXD: if (rx_en_q && !rx_flags.empty) begin
        reg_rdata[SW]     = 1'b1;
        reg_rdata[SW-1:0] = rx_head;
      end
      A_IEN: begin
        reg_rdata[EV_W-1:0]  = ien_q;
        reg_rdata[IEN_GLOBAL] = gen_q;
      end
      A_IST: begin
        reg_rdata[EV_W-1:0] = ev_stat;
        reg_rdata[ST_PEND]  = pending;
      end
      A_FST: begin
        reg_rdata[FS_TXCNT +: FLD_W] = FLD_W'(tx_cnt);
        reg_rdata[FS_TXFLG +: 4]     = tx_flags;
        reg_rdata[FS_RXCNT +: FLD_W] = FLD_W'(rx_cnt);
        reg_rdata[FS_RXFLG +: 4]     = rx_flags;
      end
      default: reg_rdata = '0;
    endcase
  end

  p_tx_starve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_q && tx_ready && !tx_valid) |=> ev_stat[EV_TX+OF_STV]);
  p_rx_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_cnt == CW'(DEPTH)) |=> ev_stat[EV_RX+OF_OVF]);
  p_xfer_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> ev_stat[EV_XFER]);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[ST_PEND] || sel != A_IST));
endmodule

// File: tb/aud_fifo_irq_bench.sv
module aud_fifo_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_re = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [15:0] tx_data, rx_data = 0;
  logic tx_dma_req, rx_dma_req, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_fifo_irq u_aud_fifo_irq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
  );

  // reference model state
  int unsigned txq[$], rxq[$];
  bit m_txen, m_rxen, m_txdma, m_rxdma, m_gen;
  int unsigned m_txthr, m_rxthr;
  logic [12:0] m_ien, m_stat;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [3:0] lvl(input int c);
    return {c == 0, c <= 2, c == DEPTH, c >= DEPTH - 2};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [31:0] e;
    bit pend, etv;
    pend = |(m_stat & m_ien);
    etv = m_txen && txq.size() > 0;
    chk(tx_valid === etv, "R1", "tx_valid", 32'(tx_valid), 32'(etv));
    e = etv ? txq[0] : 0;
    chk(tx_data === e[15:0], "R1", "tx_data", 32'(tx_data), e);
    chk(rx_ready === m_rxen, "R2", "rx_ready", 32'(rx_ready), 32'(m_rxen));
    chk(irq === (m_gen && pend), "R8", "irq", 32'(irq), 32'(m_gen && pend));
    e = 32'(m_txdma && m_txen && txq.size() <= m_txthr);
    chk(tx_dma_req === e[0], "R9", "tx_dma_req", 32'(tx_dma_req), e);
    e = 32'(m_rxdma && m_rxen && rxq.size() >= m_rxthr);
    chk(rx_dma_req === e[0], "R9", "rx_dma_req", 32'(rx_dma_req), e);
    case (reg_addr)
      3'd0: begin
        e = (32'(m_rxen) << 1) | (32'(m_txen) << 2) | (32'(m_rxdma) << 5) |
            (32'(m_txdma) << 6) | (m_rxthr << 7) | (m_txthr << 13);
        chk(reg_rdata === e, "R11", "ctrl read", reg_rdata, e);
      end
      3'd2: begin
        e = (m_rxen && rxq.size() > 0) ? (32'h1_0000 | rxq[0]) : 0;
        chk(reg_rdata === e, "R2", "rx data read", reg_rdata, e);
      end
      3'd3: begin
        e = 32'(m_ien) | (32'(m_gen) << 14);
        chk(reg_rdata === e, "R11", "enable read", reg_rdata, e);
      end
      3'd4: begin
        e = 32'(m_stat) | (32'(pend) << 13);
        chk(reg_rdata === e, "R6", "status read", reg_rdata, e);
      end
      3'd5: begin
        e = (32'(txq.size()) << 14) | (32'(lvl(txq.size())) << 10) |
            (32'(rxq.size()) << 4) | 32'(lvl(rxq.size()));
        chk(reg_rdata === e, "R3", "fifo status read", reg_rdata, e);
      end
      default: chk(reg_rdata === 0, "R11", "unused read", reg_rdata, 0);
    endcase
  endtask

  task automatic step();
    logic [12:0] set, clr;
    bit txpop;
    int tc, rc;
    set = 0;
    tc = txq.size();
    rc = rxq.size();
    if (m_txen) set[11:8] = lvl(tc);
    if (m_rxen) set[5:2] = lvl(rc);
    txpop = tx_ready && m_txen && tc > 0;
    if (m_txen && tx_ready && tc == 0) set[7] = 1;            // R5
    if (txpop || (rx_valid && m_rxen)) set[12] = 1;           // R6
    if (!m_txen) txq.delete();                                // R10
    if (!m_rxen) rxq.delete();
    if (txpop) void'(txq.pop_front());
    if (reg_we && reg_addr == 3'd1 && m_txen) begin
      if (tc == DEPTH) set[6] = 1;                            // R4
      else txq.push_back(reg_wdata[15:0]);
    end
    if (m_rxen && reg_re && reg_addr == 3'd2) begin
      if (rc == 0) set[1] = 1;
      else void'(rxq.pop_front());
    end
    if (rx_valid && m_rxen) begin
      if (rc == DEPTH) set[0] = 1;
      else rxq.push_back(rx_data);
    end
    clr = (reg_we && reg_addr == 3'd6) ? reg_wdata[12:0] : 13'h0;
    m_stat = (m_stat & ~clr) | set;                           // R7
    if (reg_we && reg_addr == 3'd0) begin
      m_rxen = reg_wdata[1]; m_txen = reg_wdata[2];
      m_rxdma = reg_wdata[5]; m_txdma = reg_wdata[6];
      m_rxthr = reg_wdata[12:7]; m_txthr = reg_wdata[18:13];
    end
    if (reg_we && reg_addr == 3'd3) begin
      m_ien = reg_wdata[12:0]; m_gen = reg_wdata[14];
    end
  endtask

  task automatic cyc(input bit we, input bit re, input int a, input logic [31:0] wd,
                     input bit txr, input bit rxv, input logic [15:0] rxd);
    @(negedge clk);
    reg_we = we; reg_re = re; reg_addr = 3'(a); reg_wdata = wd;
    tx_ready = txr; rx_valid = rxv; rx_data = rxd;
    #1;
    compare();
    step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic rd(input int a);
    cyc(0, 0, a, 0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cyc(1, 0, a, d, 0, 0, 0);
  endtask

  localparam logic [31:0] CTRL_ALL = (32'd4 << 13) | (32'd6 << 7) | 32'h66;

  initial begin
    m_txen = 0; m_rxen = 0; m_txdma = 0; m_rxdma = 0; m_gen = 0;
    m_txthr = 0; m_rxthr = 0; m_ien = 0; m_stat = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11 R3 reset values
    for (int a = 0; a < 8; a++) rd(a);
    wr(3, 32'h5FFF);
    wr(0, CTRL_ALL);
    rd(4); rd(5); rd(0); rd(3);
    // R1 R4: fill TX beyond depth
    for (int i = 0; i < DEPTH + 3; i++) wr(1, 32'h0000_1000 + i);
    rd(5); rd(4);
    // R7: clear everything while full persists (set wins)
    wr(6, 32'h1FFF);
    rd(4); rd(5);
    // R1 R5 R9: drain under random ready until starvation
    for (int i = 0; i < 90; i++) cyc(0, 0, 5, 0, lf[0] | lf[3], 0, 0);
    rd(4);
    // R2 R4: RX burst beyond depth
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, 0, 5, 0, 0, 1, 16'h2000 + 16'(i));
    rd(4);
    // R2 R5: drain RX by reads past empty
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, 1, 2, 0, 0, 0, 0);
    rd(4); rd(5);
    wr(6, 32'h1FFF);
    rd(4);
    // R10: part-fill TX and RX, then disable both
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 32'h3000 + i, 0, 1, 16'h4000 + 16'(i));
    rd(5);
    wr(0, 32'h0);
    rd(5); rd(5); rd(2); rd(4);
    wr(0, CTRL_ALL);
    rd(5);
    // R8: global enable off, then only one event enabled
    wr(3, 32'h0FFF);
    rd(4);
    wr(3, 32'h4000 | 32'h0002);
    rd(4);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      a = (lf[2:1] == 0) ? 1 : (lf[2:1] == 1) ? 2 : (lf[2:1] == 2) ? 4 : 5;
      cyc(lf[4] && a == 1, lf[5], a, 32'h5000 + i, lf[6], lf[7] & lf[8], 16'h6000 + 16'(i));
      if (i == 200) wr(0, (32'd20 << 13) | (32'd3 << 7) | 32'h66);
      if (i == 300) wr(6, 32'h0FFF);
    end
    rd(4); rd(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule